// File: doc/BRIEF.md
# Dual-Pathway Spiking Layer Engine

This block evaluates one layer of leaky integrate-and-fire neurons per timestep. It has two paths. The fast path is driven by events: a stream of active input indices arrives, and each index adds one row of input weights to every neuron's current accumulator. The slow path is a short memory vector held in a small local array. At the end of each timestep it is projected through a second weight array into a per-neuron bias. Every k-th timestep the memory is rewritten in place from the layer's own output spikes, using a decaying linear rule.

A timestep ends when the input stream carries an end marker. The engine then adds the memory bias and applies leak and threshold to all neurons at once. It emits the index of every neuron that fired, followed by an end beat. If the dilation counter reads zero, it then runs the memory read-modify-write, one element per cycle, before it accepts input again. Weights are written through a plain load port. Leak, threshold, the two memory coefficients and the dilation factor are configuration inputs, and they are held steady while a timestep is in flight.

Top module: `dps_layer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. All membranes, accumulators, memory elements and the dilation counter are zero, so a timestep with no input spikes and zero weights produces only the end beat.
- R2: An input beat with in_eot=0 adds Wx[in_idx][n] to the accumulator of every neuron n, with 16-bit signed saturation after each add. A repeated index is added once per beat.
- R3: in_ready is 1 only while the engine collects input. It is 0 from the cycle after the end marker is accepted until the output end beat has been accepted and any memory update has completed.
- R4: At timestep end, each neuron computes v' = sat16(v - (v >>> leak) + acc + bias). The shift is arithmetic. The neuron fires when v' >= threshold (signed), and v then becomes 0 if it fired and v' otherwise. Accumulators clear to zero.
- R5: The bias of neuron n is sat16((sum over d of Wm[n][d]*m[d]) >>> 15), where Wm is in Q1.15 format.
- R6: Output beats carry the indices of the firing neurons in ascending order, one index per accepted beat and each index at most once. They are followed by exactly one beat with out_eot=1 and out_idx=0.
- R7: While out_valid=1 and out_ready=0, out_valid, out_idx and out_eot hold their values into the next cycle.
- R8: A memory update sets, for each d, g = sat16(sum of Wg[d][n] over the neurons that fired this timestep) and m[d] = sat16(((alpha*m[d]) >>> 15) + ((beta*g) >>> 15)). Alpha and beta are in Q1.15 format.
- R9: The memory update runs only in timesteps where the dilation counter is 0. When the end beat is accepted, the counter advances by one and wraps to 0 once it reaches k-1, where k = cfg_dilation and a value of 0 is treated as 1. In all other timesteps the memory is unchanged.
- R10: A load beat with wl_sel=0 writes Wx at address i*N+n, wl_sel=1 writes Wm at address n*D+d, wl_sel=2 writes Wg at address d*N+n. wl_sel=3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_alpha | input | 16 | Memory decay coefficient, Q1.15 |
| cfg_beta | input | 16 | Spike drive coefficient, Q1.15 |
| cfg_leak | input | LW | Membrane leak shift amount |
| cfg_thresh | input | 16 | Signed firing threshold |
| cfg_dilation | input | KW | Timesteps between memory updates (0 acts as 1) |
| wl_valid | input | 1 | Weight load strobe |
| wl_sel | input | 2 | Target weight array |
| wl_addr | input | LA | Flat address inside the array |
| wl_data | input | 16 | Signed weight value |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Engine accepts input |
| in_idx | input | IW | Active input spike index |
| in_eot | input | 1 | Beat is the end-of-timestep marker |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts output |
| out_idx | output | NW | Index of a firing neuron |
| out_eot | output | 1 | Beat closes the timestep |

## Verification
The hardest behaviour to reach from the ports is the slow path. Memory contents show up only as a bias in later timesteps, and only on the timesteps the dilation counter selects. A wrong update or a wrong dilation phase stays hidden until enough activity has built up the memory and a neuron's firing depends on it. The stimulus therefore loads large memory-projection weights, runs long deterministic spike schedules under dilation factors of 1, 3 and 0, and throttles the output side, so that the memory drifts and decides which neurons fire. The same stimulus also drives accumulator saturation in both directions.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef logic signed [15:0] word_t;

    typedef enum logic [2:0] {
        PH_ACC,
        PH_BIAS,
        PH_FIRE,
        PH_EMIT,
        PH_MEM
    } phase_e;

    // clamp a wide signed value into the 16-bit signed range
    function automatic word_t sat_word(input logic signed [63:0] x);
        if (x > 64'sd32767) begin
            return 16'sh7fff;
        end
        if (x < -64'sd32768) begin
            return 16'sh8000;
        end
        return word_t'(x[15:0]);
    endfunction

endpackage

// File: rtl/dps_neuron_array.sv
module dps_neuron_array
    import dps_pkg::*;
#(
    parameter int N  = 8,
    parameter int LW = 4
) (
    input  logic [N-1:0][15:0] v_q,
    input  logic [N-1:0][15:0] acc,
    input  logic [N-1:0][15:0] bias,
    input  logic [LW-1:0]      leak,
    input  logic [15:0]        thresh,
    output logic [N-1:0][15:0] v_d,
    output logic [N-1:0]       fire
);

    for (genvar g = 0; g < N; g++) begin : g_nrn
        logic signed [63:0] vw_g;
        logic signed [63:0] tot_g;
        word_t              nv_g;

        assign vw_g  = 64'($signed(v_q[g]));
        assign tot_g = vw_g - (vw_g >>> leak)
                     + 64'($signed(acc[g])) + 64'($signed(bias[g]));
        assign nv_g  = sat_word(tot_g);
        assign fire[g] = (nv_g >= $signed(thresh));
        assign v_d[g]  = fire[g] ? 16'h0000 : nv_g;
    end

endmodule

// File: rtl/dps_first_set.sv
module dps_first_set #(
    parameter int N  = 8,
    parameter int NW = 3
) (
    input  logic [N-1:0]  mask,
    output logic [NW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = NW'(i);
            end
        end
    end

    assign any = |mask;

endmodule

// File: rtl/dps_mem_unit.sv
module dps_mem_unit
    import dps_pkg::*;
#(
    parameter int N  = 8,
    parameter int D  = 2,
    parameter int DA = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [15:0]           alpha,
    input  logic [15:0]           beta,
    input  logic [N-1:0]          fired,
    input  logic [D*N-1:0][15:0]  wg,
    input  logic [DA-1:0]         rd_addr,
    output logic [15:0]           rd_data,
    output logic                  busy,
    output logic                  wr
);

    typedef struct packed {
        logic          busy;
        logic [DA-1:0] idx;
    } mst_t;

    mst_t               s_d, s_q;
    logic [D-1:0][15:0] mem_q;
    logic [DA-1:0]      addr;
    logic signed [63:0] gsum, pa, pb;
    word_t              g_val, nv;

    assign addr    = s_q.busy ? s_q.idx : rd_addr;
    assign rd_data = mem_q[addr];
    assign busy    = s_q.busy;

    always_comb begin
        s_d  = s_q;
        wr   = 1'b0;
        gsum = '0;
        // output-stationary: one memory element gathers its whole drive
        for (int n = 0; n < N; n++) begin
            if (fired[n]) begin
                gsum = gsum + 64'($signed(wg[int'(s_q.idx) * N + n]));
            end
        end
        g_val = sat_word(gsum);
        pa    = 64'($signed(alpha)) * 64'($signed(rd_data));
        pb    = 64'($signed(beta)) * 64'($signed(g_val));
        nv    = sat_word((pa >>> 15) + (pb >>> 15));
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.idx  = '0;
            end
        end else begin
            wr = 1'b1;
            if (int'(s_q.idx) == D - 1) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q   <= '0;
            mem_q <= '0;
        end else begin
            s_q <= s_d;
            if (wr) begin
                mem_q[s_q.idx] <= nv;
            end
        end
    end

endmodule

// File: rtl/dps_layer.sv
module dps_layer
    import dps_pkg::*;
#(
    parameter int N   = 8,
    parameter int NIN = 16,
    parameter int D   = 2,
    parameter int LW  = 4,
    parameter int KW  = 4,
    localparam int IW    = $clog2(NIN),
    localparam int NW    = $clog2(N),
    localparam int WX_SZ = NIN * N,
    localparam int WM_SZ = N * D,
    localparam int WG_SZ = D * N,
    localparam int LA    = $clog2((WX_SZ > WM_SZ) ? WX_SZ : WM_SZ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   cfg_alpha,
    input  logic [15:0]   cfg_beta,
    input  logic [LW-1:0] cfg_leak,
    input  logic [15:0]   cfg_thresh,
    input  logic [KW-1:0] cfg_dilation,
    input  logic          wl_valid,
    input  logic [1:0]    wl_sel,
    input  logic [LA-1:0] wl_addr,
    input  logic [15:0]   wl_data,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [IW-1:0] in_idx,
    input  logic          in_eot,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [NW-1:0] out_idx,
    output logic          out_eot
);

    localparam int DA = (D > 1) ? $clog2(D) : 1;
    localparam int BW = 34 + DA;

    typedef struct packed {
        phase_e                phase;
        logic [N-1:0][15:0]    acc;
        logic [N-1:0][15:0]    vm;
        logic [N-1:0][BW-1:0]  bacc;
        logic [N-1:0]          fired;
        logic [N-1:0]          pend;
        logic [DA-1:0]         bidx;
        logic [KW-1:0]         dil;
    } st_t;

    st_t st_d, st_q;

    logic [WX_SZ-1:0][15:0] wx_q;
    logic [WM_SZ-1:0][15:0] wm_q;
    logic [WG_SZ-1:0][15:0] wg_q;

    logic [N-1:0][15:0] bias;
    logic [N-1:0][15:0] v_next;
    logic [N-1:0]       fire;
    logic [NW-1:0]      pick_idx;
    logic               pick_any;
    logic [15:0]        mem_rd;
    logic               mem_busy;
    logic               mem_wr;
    logic               mem_start;
    logic               dil_zero;
    logic [KW-1:0]      k_eff;

    // ---------------- weight arrays ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wx_q <= '0;
            wm_q <= '0;
            wg_q <= '0;
        end else if (wl_valid) begin
            case (wl_sel)
                2'd0: if (int'(wl_addr) < WX_SZ) wx_q[wl_addr] <= wl_data;
                2'd1: if (int'(wl_addr) < WM_SZ) wm_q[wl_addr] <= wl_data;
                2'd2: if (int'(wl_addr) < WG_SZ) wg_q[wl_addr] <= wl_data;
                default: ;
            endcase
        end
    end

    // ---------------- datapath submodules ----------------
    for (genvar g = 0; g < N; g++) begin : g_bias
        assign bias[g] = sat_word(64'($signed(st_q.bacc[g])) >>> 15);
    end

    dps_neuron_array #(.N(N), .LW(LW)) u_nrn (
        .v_q   (st_q.vm),
        .acc   (st_q.acc),
        .bias  (bias),
        .leak  (cfg_leak),
        .thresh(cfg_thresh),
        .v_d   (v_next),
        .fire  (fire)
    );

    dps_first_set #(.N(N), .NW(NW)) u_pick (
        .mask(st_q.pend),
        .idx (pick_idx),
        .any (pick_any)
    );

    dps_mem_unit #(.N(N), .D(D), .DA(DA)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (mem_start),
        .alpha  (cfg_alpha),
        .beta   (cfg_beta),
        .fired  (st_q.fired),
        .wg     (wg_q),
        .rd_addr(st_q.bidx),
        .rd_data(mem_rd),
        .busy   (mem_busy),
        .wr     (mem_wr)
    );

    // ---------------- control ----------------
    assign dil_zero  = (st_q.dil == '0);
    assign k_eff     = (cfg_dilation == '0) ? KW'(1) : cfg_dilation;
    assign in_ready  = (st_q.phase == PH_ACC);
    assign out_valid = (st_q.phase == PH_EMIT);
    assign out_eot   = out_valid && !pick_any;
    assign out_idx   = pick_any ? pick_idx : '0;

    always_comb begin
        st_d      = st_q;
        mem_start = 1'b0;
        case (st_q.phase)
            PH_ACC: begin
                if (in_valid) begin
                    if (in_eot) begin
                        st_d.phase = PH_BIAS;
                        st_d.bidx  = '0;
                        st_d.bacc  = '0;
                    end else if (int'(in_idx) < NIN) begin
                        // input-stationary: one weight row touches every neuron
                        for (int n = 0; n < N; n++) begin
                            st_d.acc[n] = sat_word(64'($signed(st_q.acc[n]))
                                + 64'($signed(wx_q[int'(in_idx) * N + n])));
                        end
                    end
                end
            end
            PH_BIAS: begin
                for (int n = 0; n < N; n++) begin
                    st_d.bacc[n] = st_q.bacc[n] + BW'(
                        64'($signed(wm_q[n * D + int'(st_q.bidx)]))
                        * 64'($signed(mem_rd)));
                end
                if (int'(st_q.bidx) == D - 1) begin
                    st_d.phase = PH_FIRE;
                end else begin
                    st_d.bidx = st_q.bidx + 1'b1;
                end
            end
            PH_FIRE: begin
                st_d.vm    = v_next;
                st_d.fired = fire;
                st_d.pend  = fire;
                st_d.acc   = '0;
                st_d.phase = PH_EMIT;
            end
            PH_EMIT: begin
                if (out_ready) begin
                    if (pick_any) begin
                        st_d.pend[pick_idx] = 1'b0;
                    end else begin
                        st_d.dil = (st_q.dil >= k_eff - 1'b1) ? '0 : st_q.dil + 1'b1;
                        if (dil_zero) begin
                            mem_start  = 1'b1;
                            st_d.phase = PH_MEM;
                        end else begin
                            st_d.phase = PH_ACC;
                        end
                    end
                end
            end
            PH_MEM: begin
                if (!mem_busy) begin
                    st_d.phase = PH_ACC;
                end
            end
            default: st_d.phase = PH_ACC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_ACC;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dps_layer_chk.sv
module dps_layer_chk #(
    parameter int NW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [NW-1:0] out_idx,
    input logic          out_eot,
    input logic          mem_wr,
    input logic          dil_zero
);

    logic          seen_q;
    logic          have_q;
    logic [NW-1:0] last_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            have_q  <= 1'b0;
            last_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            if (out_valid && out_ready) begin
                have_q <= !out_eot;
                last_q <= out_idx;
                if (out_eot) begin
                    armed_q <= dil_zero;
                end
            end else if (in_ready) begin
                armed_q <= 1'b0;
            end
        end
    end

    // R1: first active cycle shows the idle handshake state
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (!out_valid && in_ready));

    // R3: input is never accepted while results are pending
    a_r3_no_input_when_emitting: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R6: indices inside one timestep strictly ascend
    a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_eot && have_q) |-> (out_idx > last_q));

    // R7: stalled output holds its payload
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_eot)));

    // R9: memory writes only follow an end beat taken at dilation phase zero
    a_r9_gated_update: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> armed_q);

endmodule

bind dps_layer dps_layer_chk #(.NW(NW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_idx  (out_idx),
    .out_eot  (out_eot),
    .mem_wr   (mem_wr),
    .dil_zero (dil_zero)
);

// File: tb/dps_layer_test.sv
module dps_layer_test;

    localparam int N   = 8;
    localparam int NIN = 16;
    localparam int D   = 2;
    localparam int LW  = 4;
    localparam int KW  = 4;
    localparam int IW  = 4;
    localparam int NW  = 3;
    localparam int LA  = 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [15:0]   cfg_alpha, cfg_beta, cfg_thresh;
    logic [LW-1:0] cfg_leak;
    logic [KW-1:0] cfg_dilation;
    logic          wl_valid;
    logic [1:0]    wl_sel;
    logic [LA-1:0] wl_addr;
    logic [15:0]   wl_data;
    logic          in_valid, in_ready, in_eot;
    logic [IW-1:0] in_idx;
    logic          out_valid, out_ready, out_eot;
    logic [NW-1:0] out_idx;

    always #5 clk = ~clk;

    dps_layer #(.N(N), .NIN(NIN), .D(D), .LW(LW), .KW(KW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_alpha(cfg_alpha), .cfg_beta(cfg_beta), .cfg_leak(cfg_leak),
        .cfg_thresh(cfg_thresh), .cfg_dilation(cfg_dilation),
        .wl_valid(wl_valid), .wl_sel(wl_sel), .wl_addr(wl_addr), .wl_data(wl_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx), .in_eot(in_eot),
        .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx), .out_eot(out_eot)
    );

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int spk_q[$];
    bit bp_mode = 1'b0;
    int cyc = 0;
    bit stall_q = 1'b0;
    logic [NW-1:0] hold_idx;
    logic          hold_eot;

    // reference state built from the requirements
    longint wx[NIN*N];
    longint wm[N*D];
    longint wg[D*N];
    longint vmod[N];
    longint amod[N];
    longint mmod[D];
    int     dcnt;

    function automatic longint sat(input longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int sel, input int addr, input longint data);
        @(negedge clk);
        wl_valid = 1'b1;
        wl_sel   = 2'(sel);
        wl_addr  = LA'(addr);
        wl_data  = 16'(data);
        @(negedge clk);
        wl_valid = 1'b0;
        if (sel == 0) wx[addr] = data;
        if (sel == 1) wm[addr] = data;
        if (sel == 2) wg[addr] = data;
    endtask

    task automatic send(input int idx, input bit eot);
        in_valid = 1'b1;
        in_idx   = IW'(idx);
        in_eot   = eot;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_eot   = 1'b0;
    endtask

    // driver: sends one timestep and pushes the expected output beats
    task automatic step();
        bit     f[N];
        longint keff;
        @(negedge clk);
        foreach (spk_q[j]) begin
            for (int n = 0; n < N; n++) amod[n] = sat(amod[n] + wx[spk_q[j]*N + n]);
            send(spk_q[j], 1'b0);
        end
        send(0, 1'b1);
        check(in_ready == 1'b0, "R3 in_ready after end marker", longint'(in_ready), 0);
        for (int n = 0; n < N; n++) begin
            longint bs, bias, nv;
            bs = 0;
            for (int d = 0; d < D; d++) bs += wm[n*D + d] * mmod[d];
            bias = sat(bs >>> 15);
            nv = sat(vmod[n] - (vmod[n] >>> cfg_leak) + amod[n] + bias);
            f[n] = (nv >= longint'($signed(cfg_thresh)));
            vmod[n] = f[n] ? 0 : nv;
            amod[n] = 0;
            if (f[n]) exp_q.push_back(n);
        end
        exp_q.push_back(-1);
        if (dcnt == 0) begin
            for (int d = 0; d < D; d++) begin
                longint gs;
                gs = 0;
                for (int n = 0; n < N; n++) if (f[n]) gs += wg[d*N + n];
                gs = sat(gs);
                mmod[d] = sat(((longint'($signed(cfg_alpha)) * mmod[d]) >>> 15)
                            + ((longint'($signed(cfg_beta)) * gs) >>> 15));
            end
        end
        keff = (cfg_dilation == 0) ? 1 : longint'(cfg_dilation);
        dcnt = (dcnt >= keff - 1) ? 0 : dcnt + 1;
        spk_q.delete();
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || !in_ready) @(negedge clk);
    endtask

    // monitor: throttles the consumer side and pops the scoreboard
    always @(negedge clk) begin
        cyc++;
        if (rst_n === 1'b1) begin
            if (stall_q) begin
                check(out_valid && out_idx == hold_idx && out_eot == hold_eot,
                      "R7 stalled beat held", longint'(out_idx), longint'(hold_idx));
            end
            out_ready = bp_mode ? (cyc % 3 != 1) : 1'b1;
            stall_q   = out_valid && !out_ready;
            hold_idx  = out_idx;
            hold_eot  = out_eot;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected output beat", longint'(out_idx), -2);
                end else begin
                    int e, a;
                    e = exp_q.pop_front();
                    a = out_eot ? -1 : int'(out_idx);
                    check(a == e, "R4/R5/R6/R8/R9 output beat", a, e);
                end
            end
        end else begin
            out_ready = 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R6 watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_eot = 1'b0; in_idx = '0;
        wl_valid = 1'b0; wl_sel = '0; wl_addr = '0; wl_data = '0;
        cfg_alpha = 16'd24576; cfg_beta = 16'd16384;
        cfg_leak = 4'd2; cfg_thresh = 16'd300; cfg_dilation = 4'd1;
        foreach (wx[i]) wx[i] = 0;
        foreach (wm[i]) wm[i] = 0;
        foreach (wg[i]) wg[i] = 0;
        foreach (vmod[i]) begin vmod[i] = 0; amod[i] = 0; end
        foreach (mmod[i]) mmod[i] = 0;
        dcnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle handshake state after reset
        check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
        // R1: zero state gives a lone end beat
        step();
        drain();

        // R10: load all three arrays, then a select-3 write that must change nothing
        for (int i = 0; i < NIN; i++)
            for (int n = 0; n < N; n++)
                load(0, i*N + n, ((i*53 + n*29) % 257) - 90);
        for (int n = 0; n < N; n++) begin
            load(1, n*D + 0, n*6000 - 12000);
            load(1, n*D + 1, (7 - n)*3000);
            load(2, 0*N + n, 40 + n*9);
            load(2, 1*N + n, -(20 + n*3));
        end
        load(3, 0, 32767);
        load(3, 5, -32768);

        // R2: a single event, then a repeated index
        spk_q.push_back(3); step();
        spk_q.push_back(5); spk_q.push_back(5); spk_q.push_back(5); step();
        drain();

        // R8 R9: long schedule with k=1, then k=3 under backpressure, then k=0
        for (int t = 0; t < 40; t++) begin
            if (t == 14) begin drain(); cfg_dilation = 4'd3; bp_mode = 1'b1; end
            if (t == 30) begin drain(); cfg_dilation = 4'd0; cfg_leak = 4'd1; end
            for (int j = 0; j < (t*3) % 7; j++) spk_q.push_back((t*5 + j*7 + j*j) % 16);
            step();
        end
        drain();

        // R2 R4: positive and negative accumulator saturation
        for (int n = 0; n < N; n++) load(0, 15*N + n, 32767);
        for (int n = 0; n < N; n++) load(0, 14*N + n, -32768);
        spk_q.push_back(15); spk_q.push_back(15); spk_q.push_back(15); step();
        spk_q.push_back(14); spk_q.push_back(14); step();
        step();
        spk_q.push_back(15); step();
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule